// File: doc/BRIEF.md
# Banked Buffer Window Mapper

This block sits between a host and a large on-board buffer memory that the host can only see through an 8 KB window. The host presents a buffer base address and a 16-bit word offset. The block forms a byte address, splits it into a bank number and an offset inside the window, and programs the bank-select register only when the bank actually changes. It then issues the read or write on a simple synchronous memory-side port.

The block keeps one cached copy of the last bank it selected. A request that needs a new bank is held for one cycle while the bank-select write goes out. A request that hits the cached bank reaches the memory port in the same cycle. A separate configuration strobe checks a proposed host window base address against a fixed pattern. A legal base is latched and bank 0 is selected. An illegal base raises an error flag and leaves the window configuration as it was.

Top module: `bank_window_map`

## Requirements
- R1: The byte address is `req_base + 2*req_woff`, taken modulo 2^20. `mem_addr` carries its low 13 bits.
- R2: The bank number is byte address bits 19:13 (7 bits), so each bank spans 8 KB.
- R3: `bank_wr` pulses only when the computed bank differs from the cached bank, or when no bank is cached. `bank_wdata` carries an enable bit at bit 7 set to 1 and the bank number in bits 6:0.
- R4: A request that needs a bank switch sees `req_ready` low and `bank_wr` high for exactly one cycle. In the next cycle, with the request held, `req_ready` is high and the access is issued. A request that hits the cached bank is issued in the same cycle.
- R5: After reset no bank is cached, so the first access always writes the bank register, even for bank 0.
- R6: A window base is legal if and only if `(cfg_base & ~0x1E000) == 0xC0000`. A legal base is copied to `win_base`, sets `win_en` and clears `cfg_err` on the next cycle.
- R7: An illegal window base sets `cfg_err` and leaves `win_base` and `win_en` unchanged.
- R8: A legal configuration writes the bank register with bank 0 in the same cycle and caches bank 0. A later bank-0 access is then not stalled. A configuration strobe takes priority over a request, so `req_ready` is low in that cycle.
- R9: `odd_off` is high while a request is present and bit 0 of its in-window offset is 1.
- R10: On an issued access, `mem_we` equals `req_we` and `mem_wdata` equals `req_wdata`. After an issued read, `rd_valid` is high in the next cycle and `rdata` shows `mem_rdata`.
- R11: After reset `bank_wr`, `win_en`, `cfg_err` and `rd_valid` are 0, and `win_base` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Window base configuration strobe |
| cfg_base | input | 20 | Proposed host window base address |
| win_base | output | 20 | Accepted window base |
| win_en | output | 1 | A legal window base has been accepted |
| cfg_err | output | 1 | Last configuration attempt was rejected |
| req | input | 1 | Access request, held until ready |
| req_we | input | 1 | 1 = write, 0 = read |
| req_base | input | 20 | Buffer base byte address |
| req_woff | input | 16 | Word offset added to the base |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Access issued this cycle |
| odd_off | output | 1 | In-window offset of the request is odd |
| rdata | output | 16 | Read data |
| rd_valid | output | 1 | Read data valid |
| bank_wr | output | 1 | Bank-select register write strobe |
| bank_wdata | output | 8 | Bank-select value: enable bit and bank number |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 13 | Byte offset inside the window |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after a read |

## Verification
A wrong cached bank shows up at the ports on the very next request. Either a bank write appears where none is due, or a needed one is missing and the access goes out with `req_ready` high in the first cycle. The bench tracks the cached bank itself and expects `bank_wr` and the stall exactly when the bank changes. It also compares every issued `mem_addr` with its own address arithmetic. A configuration error shows on `win_base`, `win_en` and `cfg_err` one cycle after the strobe, and as an unexpected stall on the first bank-0 access that follows.

// File: rtl/bank_window_map.sv
module bank_window_map #(
  parameter int ADDR_W = 20,
  parameter int WIN_BITS = 13,
  parameter int OFF_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] WIN_FIXED = 20'hC0000,
  parameter logic [ADDR_W-1:0] WIN_SEL_MASK = 20'h1E000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [ADDR_W-1:0] cfg_base,
  output logic [ADDR_W-1:0] win_base,
  output logic              win_en,
  output logic              cfg_err,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_woff,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              odd_off,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              bank_wr,
  output logic [ADDR_W-WIN_BITS:0] bank_wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [WIN_BITS-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int BANK_W = ADDR_W - WIN_BITS;

  logic [ADDR_W-1:0] byte_addr;
  logic [BANK_W-1:0] bank_calc, bank_q;
  logic              bank_vld, hit, base_ok, cfg_take, switch_bank;

  assign byte_addr   = req_base + ADDR_W'({req_woff, 1'b0});
  assign bank_calc   = byte_addr[ADDR_W-1:WIN_BITS];
  assign base_ok     = (cfg_base & ~WIN_SEL_MASK) == WIN_FIXED;
  assign hit         = bank_vld && (bank_q == bank_calc);
  assign cfg_take    = cfg_valid && base_ok;
  assign switch_bank = req && !cfg_valid && !hit;

  assign bank_wr    = cfg_take || switch_bank;
  assign bank_wdata = {1'b1, cfg_take ? {BANK_W{1'b0}} : bank_calc};

  assign req_ready = req && !cfg_valid && hit;
  assign mem_en    = req_ready;
  assign mem_we    = req_ready && req_we;
  assign mem_addr  = byte_addr[WIN_BITS-1:0];
  assign mem_wdata = req_wdata;
  assign odd_off   = req && byte_addr[0];
  assign rdata     = mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_vld <= 1'b0;
      bank_q   <= '0;
      win_base <= '0;
      win_en   <= 1'b0;
      cfg_err  <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= mem_en && !req_we;
      if (cfg_valid) begin
        if (base_ok) begin
          win_base <= cfg_base;
          win_en   <= 1'b1;
          cfg_err  <= 1'b0;
          bank_q   <= '0;
          bank_vld <= 1'b1;
        end else begin
          cfg_err <= 1'b1;
        end
      end else if (switch_bank) begin
        bank_q   <= bank_calc;
        bank_vld <= 1'b1;
      end
    end
  end

  p_switch_caches_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !cfg_valid && bank_wr) |=> (bank_vld && bank_q == $past(bank_calc)));

  p_cfg_bank0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && base_ok) |=> (bank_vld && bank_q == '0 && win_en));

  p_reject_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !base_ok) |=> (cfg_err && $stable(win_base) && $stable(win_en)));

  p_read_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> rd_valid);

  p_no_rewrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !cfg_valid && bank_wr) |=> (!($stable(req_base) && $stable(req_woff) && req && !cfg_valid) || !bank_wr));

  p_odd_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_addr[0]) |-> odd_off);
endmodule

// File: tb/bank_window_map_bench.sv
`timescale 1ns/1ps
module bank_window_map_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [19:0] cfg_base = '0;
  logic [19:0] win_base;
  logic        win_en, cfg_err;
  logic        req = 1'b0, req_we = 1'b0;
  logic [19:0] req_base = '0;
  logic [15:0] req_woff = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, odd_off;
  logic [15:0] rdata;
  logic        rd_valid, bank_wr;
  logic [7:0]  bank_wdata;
  logic        mem_en, mem_we;
  logic [12:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  int checks = 0, fails = 0;
  logic        m_vld = 1'b0;
  logic [6:0]  m_bank = '0;
  logic [19:0] m_win = '0;
  logic        m_en = 1'b0, m_err = 1'b0;

  always #2 clk = ~clk;

  bank_window_map u_bank_window_map (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_base(cfg_base),
    .win_base(win_base), .win_en(win_en), .cfg_err(cfg_err),
    .req(req), .req_we(req_we), .req_base(req_base), .req_woff(req_woff),
    .req_wdata(req_wdata), .req_ready(req_ready), .odd_off(odd_off),
    .rdata(rdata), .rd_valid(rd_valid), .bank_wr(bank_wr), .bank_wdata(bank_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata));

  always @(posedge clk) if (mem_en && !mem_we) mem_rdata <= {3'b101, mem_addr};

  function automatic logic [19:0] exp_byte(logic [19:0] b, logic [15:0] w);
    return b + {3'b000, w, 1'b0};
  endfunction

  function automatic logic legal_base(logic [19:0] b);
    return (b & ~20'h1E000) == 20'hC0000;
  endfunction

  task automatic chk(logic ok, string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic do_access(logic [19:0] b, logic [15:0] w, logic we, logic [15:0] d);
    logic [19:0] eb;
    logic need;
    @(negedge clk);
    req = 1'b1; req_we = we; req_base = b; req_woff = w; req_wdata = d;
    #1;
    eb = exp_byte(b, w);
    need = !m_vld || (m_bank != eb[19:13]);
    chk(bank_wr == need, "R3 bank write decision", bank_wr, need);
    chk(odd_off == eb[0], "R9 odd offset flag", odd_off, eb[0]);
    if (need) begin
      chk(bank_wdata == {1'b1, eb[19:13]}, "R2 R3 bank select value", bank_wdata, {1'b1, eb[19:13]});
      chk(req_ready == 1'b0, "R4 stall on switch", req_ready, 0);
      @(negedge clk); #1;
      m_vld = 1'b1; m_bank = eb[19:13];
      chk(bank_wr == 1'b0, "R4 single bank write", bank_wr, 0);
    end
    chk(req_ready && mem_en, "R4 access issued", {req_ready, mem_en}, 2'b11);
    chk(mem_addr == eb[12:0], "R1 window offset", mem_addr, eb[12:0]);
    chk(mem_we == we && mem_wdata == d, "R10 write fields", {mem_we, mem_wdata}, {we, d});
    @(negedge clk);
    req = 1'b0;
    #1;
    if (!we)
      chk(rd_valid && rdata == {3'b101, eb[12:0]}, "R10 read return", {rd_valid, rdata}, {1'b1, 3'b101, eb[12:0]});
    else
      chk(!rd_valid, "R10 no read valid on write", rd_valid, 0);
  endtask

  task automatic do_cfg(logic [19:0] b, logic with_req);
    logic ok;
    ok = legal_base(b);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_base = b;
    req = with_req; req_we = 1'b0; req_base = 20'h00000; req_woff = 16'h0004;
    #1;
    chk(bank_wr == ok, "R8 cfg bank write", bank_wr, ok);
    if (ok) chk(bank_wdata == 8'h80, "R8 cfg selects bank 0", bank_wdata, 8'h80);
    chk(req_ready == 1'b0, "R8 cfg has priority", req_ready, 0);
    @(negedge clk);
    cfg_valid = 1'b0; req = 1'b0;
    if (ok) begin m_win = b; m_en = 1'b1; m_err = 1'b0; m_vld = 1'b1; m_bank = '0; end
    else m_err = 1'b1;
    #1;
    chk(win_base == m_win, ok ? "R6 base accepted" : "R7 base kept", win_base, m_win);
    chk(win_en == m_en, ok ? "R6 window enabled" : "R7 enable kept", win_en, m_en);
    chk(cfg_err == m_err, ok ? "R6 error cleared" : "R7 error set", cfg_err, m_err);
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    #1;
    chk(!bank_wr && !win_en && !cfg_err && !rd_valid && win_base == 0, "R11 reset state",
        {bank_wr, win_en, cfg_err, rd_valid, win_base}, 0);
    rst_n = 1'b1;
    // R5: first access to bank 0 still writes the bank register
    do_access(20'h00010, 16'h0003, 1'b0, 16'h0);
    do_access(20'h00010, 16'h0005, 1'b1, 16'hBEEF);
    // R2: crossing the 8 KB boundary switches bank
    do_access(20'h01FFE, 16'h0001, 1'b0, 16'h0);
    // R1: address wrap at 2^20
    do_access(20'hFFFFE, 16'h0002, 1'b1, 16'h1234);
    // R9: odd base gives odd in-window offset
    do_access(20'h04001, 16'h0010, 1'b0, 16'h0);
    do_cfg(20'hC0000, 1'b0);
    do_access(20'h00100, 16'h0020, 1'b0, 16'h0);
    do_cfg(20'hE0000, 1'b0);
    do_cfg(20'hC0001, 1'b0);
    do_cfg(20'hDE000, 1'b1);
    do_cfg(20'h40000, 1'b1);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0)
        do_cfg(r[4] ? ({12'h0C0, 8'h00} | (20'h1E000 & $urandom)) : $urandom, r[5]);
      else if (r[3:0] < 4'd8)
        do_access(20'(m_bank) << 13, 16'($urandom) & 16'h0FFF, r[6], 16'($urandom));
      else
        do_access(20'($urandom), 16'($urandom), r[6], 16'($urandom));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule